// File: doc/BRIEF.md
# Sign-Magnitude Tree Multiplier

This block multiplies two 16-bit sign-magnitude operands and returns a 32-bit sign-magnitude product. The top bit of each operand carries the sign, and the lower fifteen bits carry the magnitude. The sign of the product is the exclusive OR of the two operand signs. The magnitude comes from a 15x15 unsigned core, so bit 30 of the product is always zero.

Inside the core, an AND array forms one shifted row per multiplier bit. Layers of 3:2 carry-save compressors reduce those rows in parallel. Each layer turns every complete group of three rows into two rows and passes any leftover rows to the next layer. The layers repeat until two rows remain. A two-level carry-lookahead adder then adds those two rows.

The product is captured in an output register, so it appears one clock after the operands are presented. A zero magnitude with either sign set is passed through as a negative zero and is not normalised.

Top module: `sm_wallace_mul`

## Requirements
- R1: Product bit 31 equals the exclusive OR of bit 15 of operand A and bit 15 of operand B.
- R2: Product bit 30 is zero for every operand pair.
- R3: Product bits 29:0 equal the unsigned product of the magnitudes A[14:0] and B[14:0].
- R4: When either magnitude is zero, bits 30:0 are zero, and bit 31 still follows R1 (negative zero is kept).
- R5: The product appears at the output on the first rising clock edge after the operands are applied. While the synchronous active-high reset is sampled high, the output is cleared to zero.
- R6: Both magnitudes at all ones (0x7FFF) give bits 29:0 = 0x3FFF0001. This case exercises the longest carry chain through the final adder.
- R7: A single set bit i in magnitude A and a single set bit j in magnitude B give a magnitude with only bit i+j set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 16 | Operand A: bit 15 is the sign, bits 14:0 the magnitude |
| b_i | input | 16 | Operand B: bit 15 is the sign, bits 14:0 the magnitude |
| prod_o | output | 32 | Registered product: bit 31 is the sign, bit 30 is zero, bits 29:0 the magnitude |

## Verification
The hardest case to reach from the ports is a carry that has to travel through every lookahead group of the final adder. Only a few operand pairs leave long runs of propagate bits in the last two rows. All-ones magnitudes and all-ones-times-one are placed in the vector table for that reason, together with single-bit pairs that isolate individual array columns. A long run of pseudo-random operands then fills the compressor tree with mixed row patterns. Every sign combination is combined with zero magnitudes to pin down negative zero.

// File: rtl/smw_pkg.sv
package smw_pkg;

  // rows left after a given number of 3:2 layers
  function automatic int rows_after(input int n, input int layers);
    int r;
    r = n;
    for (int k = 0; k < layers; k++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // layers needed to bring n rows down to two
  function automatic int layer_count(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/smw_pp_array.sv
module smw_pp_array #(
  parameter int MW = 15,
  localparam int PW = 2 * MW
) (
  input  logic [MW-1:0] mcand,
  input  logic [MW-1:0] mplier,
  output logic [PW-1:0] rows [MW]
);
  // row j holds mcand AND mplier[j], shifted into columns i+j
  for (genvar j = 0; j < MW; j++) begin : g_row
    assign rows[j] = {{(PW-MW){1'b0}}, (mcand & {MW{mplier[j]}})} << j;
  end
endmodule

// File: rtl/smw_csa_tree.sv
module smw_csa_tree
  import smw_pkg::*;
#(
  parameter int M = 15,
  parameter int W = 30
) (
  input  logic [W-1:0] rows_in [M],
  output logic [W-1:0] row_a,
  output logic [W-1:0] row_b
);
  localparam int NL = layer_count(M);

  logic [W-1:0] lv [NL+1][M];

  for (genvar r = 0; r < M; r++) begin : g_in
    assign lv[0][r] = rows_in[r];
  end

  for (genvar l = 0; l < NL; l++) begin : g_lay
    localparam int RC = rows_after(M, l);
    localparam int NG = RC / 3;
    for (genvar r = 0; r < M; r++) begin : g_out
      if (r < 2 * NG) begin : g_grp
        if (r % 2 == 0) begin : g_sum
          assign lv[l+1][r] = lv[l][3*(r/2)] ^ lv[l][3*(r/2)+1] ^ lv[l][3*(r/2)+2];
        end else begin : g_cy
          assign lv[l+1][r] = ((lv[l][3*(r/2)] & lv[l][3*(r/2)+1]) |
                               (lv[l][3*(r/2)] & lv[l][3*(r/2)+2]) |
                               (lv[l][3*(r/2)+1] & lv[l][3*(r/2)+2])) << 1;
        end
      end else if (r < 2 * NG + (RC % 3)) begin : g_pass
        assign lv[l+1][r] = lv[l][3*NG + (r - 2*NG)];
      end else begin : g_zero
        assign lv[l+1][r] = '0;
      end
    end
  end

  assign row_a = lv[NL][0];
  assign row_b = lv[NL][1];
endmodule

// File: rtl/smw_cla_adder.sv
module smw_cla_adder #(
  parameter int W = 30,
  localparam int NB = (W + 3) / 4,
  localparam int WP = NB * 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  logic [WP-1:0] xp, yp, g, p, c;
  logic [NB:0]   cb;
  logic [NB-1:0] gg, pg;

  assign xp = {{(WP-W){1'b0}}, x};
  assign yp = {{(WP-W){1'b0}}, y};
  assign g  = xp & yp;
  assign p  = xp ^ yp;
  assign cb[0] = 1'b0;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    localparam int B = 4 * k;
    assign c[B]   = cb[k];
    assign c[B+1] = g[B] | (p[B] & cb[k]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & cb[k]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B]) |
                    (p[B+2] & p[B+1] & p[B] & cb[k]);
    assign pg[k]  = &p[B+3:B];
    assign gg[k]  = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1]) |
                    (p[B+3] & p[B+2] & p[B+1] & g[B]);
    assign cb[k+1] = gg[k] | (pg[k] & cb[k]);
  end

  logic [WP-1:0] sp;
  assign sp = p ^ c;
  assign s  = sp[W-1:0];
endmodule

// File: rtl/sm_wallace_mul.sv
module sm_wallace_mul #(
  parameter int OP_W = 16,
  localparam int MW = OP_W - 1,
  localparam int PW = 2 * MW,
  localparam int RW = 2 * OP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [RW-1:0] prod_o
);
  logic [PW-1:0] pp_rows [MW];
  logic [PW-1:0] fin_a, fin_b, mag_sum;
  logic          sgn;

  assign sgn = a_i[OP_W-1] ^ b_i[OP_W-1];

  smw_pp_array #(.MW(MW)) u_pp (
    .mcand (a_i[MW-1:0]),
    .mplier(b_i[MW-1:0]),
    .rows  (pp_rows)
  );

  smw_csa_tree #(.M(MW), .W(PW)) u_tree (
    .rows_in(pp_rows),
    .row_a  (fin_a),
    .row_b  (fin_b)
  );

  smw_cla_adder #(.W(PW)) u_add (
    .x(fin_a),
    .y(fin_b),
    .s(mag_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) prod_o <= '0;
    else     prod_o <= {sgn, {(RW-PW-1){1'b0}}, mag_sum};
  end
endmodule

// File: rtl/smw_checker.sv
module smw_checker #(
  parameter int OP_W = 16,
  localparam int MW = OP_W - 1,
  localparam int PW = 2 * MW,
  localparam int RW = 2 * OP_W
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] a_i,
  input logic [OP_W-1:0] b_i,
  input logic [RW-1:0]   prod_o,
  input logic [PW-1:0]   fin_a,
  input logic [PW-1:0]   fin_b,
  input logic [PW-1:0]   mag_sum
);
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  assert_sign_xor_R1: assert property (@(posedge clk) disable iff (rst)
    seen |-> prod_o[RW-1] == ($past(a_i[OP_W-1]) ^ $past(b_i[OP_W-1])));

  assert_bit30_zero_R2: assert property (@(posedge clk) disable iff (rst)
    seen |-> prod_o[RW-2] == 1'b0);

  assert_magnitude_R3: assert property (@(posedge clk) disable iff (rst)
    seen |-> prod_o[PW-1:0] ==
      ({{MW{1'b0}}, $past(a_i[MW-1:0])} * {{MW{1'b0}}, $past(b_i[MW-1:0])}));

  assert_neg_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (seen && ($past(a_i[MW-1:0]) == '0)) |-> prod_o[RW-2:0] == '0);

  assert_reset_clear_R5: assert property (@(posedge clk)
    rst |=> prod_o == '0);

  assert_final_add_R6: assert property (@(posedge clk) disable iff (rst)
    mag_sum == PW'(fin_a + fin_b));
endmodule

bind sm_wallace_mul smw_checker #(.OP_W(OP_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .prod_o (prod_o),
  .fin_a  (fin_a),
  .fin_b  (fin_b),
  .mag_sum(mag_sum)
);

// File: tb/sm_wallace_mul_bench.sv
`timescale 1ns/1ps
module sm_wallace_mul_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [31:0] prod;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sm_wallace_mul u_sm_wallace_mul (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .prod_o(prod)
  );

  // {a, b, expected product}
  localparam logic [63:0] VEC [12] = '{
    {16'h0003, 16'h0005, 32'h0000000F},  // R3 plain
    {16'h8003, 16'h0005, 32'h8000000F},  // R1 one sign
    {16'h8003, 16'h8005, 32'h0000000F},  // R1 both signs
    {16'h7FFF, 16'h7FFF, 32'h3FFF0001},  // R6 all ones
    {16'hFFFF, 16'h7FFF, 32'hBFFF0001},  // R6 with sign
    {16'h8000, 16'h1234, 32'h80000000},  // R4 negative zero
    {16'h0000, 16'h8000, 32'h80000000},  // R4 zero times negative
    {16'h8000, 16'h8000, 32'h00000000},  // R4 both signs
    {16'h4000, 16'h4000, 32'h10000000},  // R7 top bits
    {16'h0100, 16'h0010, 32'h00001000},  // R7 mid bits
    {16'h00FF, 16'h0101, 32'h0000FFFF},  // R3 carry run
    {16'h7FFF, 16'h0001, 32'h00007FFF}   // R6 one row
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb);
    @(negedge clk);
    a = va;
    b = vb;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset", prod, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 12; k++) begin
      apply(VEC[k][63:48], VEC[k][47:32]);
      check("R1/R2/R3 table", prod, VEC[k][31:0]);
    end

    // single-bit column sweep
    for (int i = 0; i < 15; i += 7) begin
      for (int j = 0; j < 15; j += 4) begin
        apply(16'(1 << i), 16'(1 << j));
        check("R7 column", prod, 32'(1) << (i + j));
      end
    end

    // reset while operands are active
    @(negedge clk);
    a = 16'h7FFF;
    b = 16'hFFFF;
    rst = 1'b1;
    @(negedge clk);
    check("R5 reset clears", prod, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R5 one-cycle latency", prod, 32'hBFFF0001);

    // pseudo-random operands against the requirement model
    begin
      logic [31:0] seed;
      seed = 32'h1F2E3D4C;
      for (int n = 0; n < 300; n++) begin
        logic [15:0] ra, rb;
        logic [31:0] exp;
        seed = seed * 32'd1664525 + 32'd1013904223;
        ra = seed[31:16];
        seed = seed * 32'd1664525 + 32'd1013904223;
        rb = seed[31:16];
        exp = {ra[15] ^ rb[15], 1'b0, 30'({15'b0, ra[14:0]} * {15'b0, rb[14:0]})};
        apply(ra, rb);
        check("R1/R2/R3 random", prod, exp);
        if (prod[30] !== 1'b0) check("R2 bit30", {31'b0, prod[30]}, 32'h0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule